// File: doc/BRIEF.md
# Integrating Overload and Short-Circuit Fault Detector

This block sits beside the pulse sequencer of a peak-current-mode switching controller. At the end of every drive pulse the sequencer reports which comparator ended that pulse. The block uses these reports to decide when a sustained overload or a run of short-circuit events must stop the converter.

Two counters carry the decision. The first is an up/down integrating timer. It climbs while the current-limit comparator is the source ending pulses, and it drains back toward zero, without being cleared, once other sources end pulses again. A short overload is therefore tolerated, while a persistent or frequently repeated one reaches the terminal count. The second counter tallies short-circuit terminations and fires only when they follow one another with no other kind of termination in between.

Each fault is reported as a one-cycle pulse to a separate fault manager. The fault manager drives a synchronous clear that empties both counters. Recovery handling is not part of this block.

Top module: `overload_short_monitor`

## Requirements
- R1: After reset both fault outputs are low, the integrating level is zero and the counting direction is downward.
- R2: A report is accepted when `termValid` is high while `drvActive` is high. An accepted report with `termSource` = 2'b01 (current limit) sets the direction to upward. From the clock edge that takes the report onward, the level rises by one on every clock edge.
- R3: An accepted report with `termSource` = 2'b00 (PWM compare), 2'b10 (short circuit) or 2'b11 (duty clamp) sets the direction to downward. From that edge the level falls by one per clock edge toward zero and is not cleared at once.
- R4: The level saturates at zero when counting down and at `OL_TICKS` when counting up.
- R5: `overloadFault` is high for exactly the one cycle after the edge on which the level reaches `OL_TICKS`. It does not fire again while the level stays at `OL_TICKS`; it fires again only after the level has dropped and climbed back.
- R6: Each accepted short-circuit report (2'b10) advances a run counter. The `SCP_RUN`-th consecutive one drives `shortFault` high for the following cycle only, and the run then restarts from zero.
- R7: Any accepted report with a source other than 2'b10 sets the short-circuit run back to zero.
- R8: A report presented while `drvActive` is low is ignored. It changes neither the direction nor the short-circuit run.
- R9: `clrCounters` is synchronous and overrides every report. It sets the level and the run to zero, sets the direction to downward, and keeps both fault outputs low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick is one count of the integrating timer |
| rstN | input | 1 | Asynchronous active-low reset |
| clrCounters | input | 1 | Synchronous clear from the fault manager |
| termValid | input | 1 | One-cycle strobe: a drive pulse has just been ended |
| termSource | input | 2 | Source that ended the pulse: 00 PWM, 01 current limit, 10 short circuit, 11 duty clamp |
| drvActive | input | 1 | Gate drive level; reports are honoured only while it is high |
| overloadFault | output | 1 | One-cycle pulse when the integrating timer expires |
| shortFault | output | 1 | One-cycle pulse on the last of a consecutive short-circuit run |

## Verification
The assertions assume that every input is a known 0 or 1 on each rising edge after reset, and that `termSource` is meaningful whenever `termValid` is high. They do not assume that reports are spaced apart, so back-to-back reports and reports arriving with the drive low remain legal. The stimulus changes all inputs only on the falling edge. Its random portion mixes dense and sparse reports, mostly with the drive high and occasionally low, and adds rare clears. The directed cases push the level to both saturation limits and break short-circuit runs on purpose.

// File: rtl/ovs_pkg.sv
package ovsPkg;

  typedef enum logic [1:0] {
    SRC_PWM    = 2'b00,
    SRC_CURLIM = 2'b01,
    SRC_SHORT  = 2'b10,
    SRC_DUTY   = 2'b11
  } termSrcE;

  typedef struct packed {
    logic clear;
    logic stepUp;
    logic stepDown;
    logic shortHit;
    logic shortBreak;
  } ctrlStrobeT;

endpackage

// File: rtl/ovs_control.sv
module ovs_control
  import ovsPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clrCounters,
  input  logic       termValid,
  input  logic [1:0] termSource,
  input  logic       drvActive,
  output ctrlStrobeT strobe
);

  termSrcE srcE;
  logic    accepted;
  logic    isCurLim;
  logic    isShort;
  logic    dirUpQ;
  logic    effUp;

  assign srcE     = termSrcE'(termSource);
  assign accepted = termValid && drvActive;
  assign isCurLim = (srcE == SRC_CURLIM);
  assign isShort  = (srcE == SRC_SHORT);

  // direction follows the latest accepted report (R2, R3, R8)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirUpQ <= 1'b0;
    end else if (clrCounters) begin
      dirUpQ <= 1'b0;
    end else if (accepted) begin
      dirUpQ <= isCurLim;
    end
  end

  // a fresh report steers the count on the very edge that takes it
  assign effUp = accepted ? isCurLim : dirUpQ;

  always_comb begin
    strobe.clear      = clrCounters;
    strobe.stepUp     = !clrCounters && effUp;
    strobe.stepDown   = !clrCounters && !effUp;
    strobe.shortHit   = !clrCounters && accepted && isShort;
    strobe.shortBreak = !clrCounters && accepted && !isShort;
  end

endmodule

// File: rtl/ovs_datapath.sv
module ovs_datapath
  import ovsPkg::*;
#(
  parameter int OL_TICKS = 40,
  parameter int SCP_RUN  = 4,
  localparam int LVL_W   = $clog2(OL_TICKS + 1),
  localparam int RUN_W   = $clog2(SCP_RUN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobe,
  output logic [LVL_W-1:0] olLevel,
  output logic             overloadFault,
  output logic             shortFault
);

  localparam logic [LVL_W-1:0] LVL_TOP  = LVL_W'(OL_TICKS);
  localparam logic [LVL_W-1:0] LVL_PRE  = LVL_W'(OL_TICKS - 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(SCP_RUN - 1);

  logic [LVL_W-1:0] levelQ;
  logic [RUN_W-1:0] runQ;
  logic             olFaultQ;
  logic             scFaultQ;
  logic             runDone;

  // integrating overload timer, saturating both ways (R2, R3, R4)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ <= '0;
    end else if (strobe.clear) begin
      levelQ <= '0;
    end else if (strobe.stepUp && (levelQ != LVL_TOP)) begin
      levelQ <= levelQ + 1'b1;
    end else if (strobe.stepDown && (levelQ != '0)) begin
      levelQ <= levelQ - 1'b1;
    end
  end

  // expiry pulse only on the step into the terminal value (R5)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      olFaultQ <= 1'b0;
    end else begin
      olFaultQ <= strobe.stepUp && (levelQ == LVL_PRE);
    end
  end

  assign runDone = (runQ == RUN_LAST);

  // consecutive short-circuit run (R6, R7)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ <= '0;
    end else if (strobe.clear || strobe.shortBreak) begin
      runQ <= '0;
    end else if (strobe.shortHit) begin
      runQ <= runDone ? '0 : runQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scFaultQ <= 1'b0;
    end else begin
      scFaultQ <= strobe.shortHit && runDone;
    end
  end

  assign olLevel       = levelQ;
  assign overloadFault = olFaultQ;
  assign shortFault    = scFaultQ;

endmodule

// File: rtl/overload_short_monitor.sv
module overload_short_monitor
  import ovsPkg::*;
#(
  parameter int OL_TICKS = 40,
  parameter int SCP_RUN  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clrCounters,
  input  logic       termValid,
  input  logic [1:0] termSource,
  input  logic       drvActive,
  output logic       overloadFault,
  output logic       shortFault
);

  localparam int LVL_W = $clog2(OL_TICKS + 1);

  ctrlStrobeT       strobe;
  logic [LVL_W-1:0] olLevel;

  ovs_control uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .clrCounters (clrCounters),
    .termValid   (termValid),
    .termSource  (termSource),
    .drvActive   (drvActive),
    .strobe      (strobe)
  );

  ovs_datapath #(
    .OL_TICKS (OL_TICKS),
    .SCP_RUN  (SCP_RUN)
  ) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .olLevel       (olLevel),
    .overloadFault (overloadFault),
    .shortFault    (shortFault)
  );

endmodule

// File: rtl/ovs_checker.sv
module ovs_checker #(
  parameter int OL_TICKS = 40,
  parameter int LVL_W    = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             clrCounters,
  input logic             termValid,
  input logic [1:0]       termSource,
  input logic             drvActive,
  input logic [LVL_W-1:0] olLevel,
  input logic             overloadFault,
  input logic             shortFault
);

  assert_level_bounded_R4: assert property (@(posedge clk) disable iff (!rstN)
    int'(olLevel) <= OL_TICKS);

  assert_level_single_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    !clrCounters |=> (int'(olLevel) - int'($past(olLevel)) <= 1) &&
                     (int'($past(olLevel)) - int'(olLevel) <= 1));

  assert_overload_one_cycle_R5: assert property (@(posedge clk) disable iff (!rstN)
    overloadFault |=> !overloadFault);

  assert_overload_at_top_R5: assert property (@(posedge clk) disable iff (!rstN)
    overloadFault |-> (int'(olLevel) == OL_TICKS) && (int'($past(olLevel)) == OL_TICKS - 1));

  assert_short_one_cycle_R6: assert property (@(posedge clk) disable iff (!rstN)
    shortFault |=> !shortFault);

  assert_short_needs_report_R8: assert property (@(posedge clk) disable iff (!rstN)
    shortFault |-> $past(termValid && drvActive && (termSource == 2'b10) && !clrCounters));

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rstN)
    clrCounters |=> (olLevel == '0) && !overloadFault && !shortFault);

endmodule

bind overload_short_monitor ovs_checker #(
  .OL_TICKS (OL_TICKS),
  .LVL_W    (LVL_W)
) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .clrCounters   (clrCounters),
  .termValid     (termValid),
  .termSource    (termSource),
  .drvActive     (drvActive),
  .olLevel       (olLevel),
  .overloadFault (overloadFault),
  .shortFault    (shortFault)
);

// File: tb/test_overload_short_monitor.sv
module test_overload_short_monitor;

  localparam int OL = 40;
  localparam int RUN = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clrCounters = 1'b0;
  logic       termValid = 1'b0;
  logic [1:0] termSource = 2'b00;
  logic       drvActive = 1'b0;
  logic       overloadFault;
  logic       shortFault;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // reference state derived from the requirements
  int mLevel = 0;
  bit mDirUp = 1'b0;
  int mRun = 0;
  bit expOl = 1'b0;
  bit expSc = 1'b0;

  overload_short_monitor #(.OL_TICKS(OL), .SCP_RUN(RUN)) i_overload_short_monitor (
    .clk           (clk),
    .rstN          (rstN),
    .clrCounters   (clrCounters),
    .termValid     (termValid),
    .termSource    (termSource),
    .drvActive     (drvActive),
    .overloadFault (overloadFault),
    .shortFault    (shortFault)
  );

  always #4 clk = ~clk;

  task automatic check(input logic act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b at %0t", what, act, exp, $time);
    end
  endtask

  function automatic void modelEdge(bit v, bit [1:0] s, bit d, bit c);
    bit acc;
    bit up;
    acc = v && d;
    if (c) begin
      mLevel = 0; mDirUp = 1'b0; mRun = 0; expOl = 1'b0; expSc = 1'b0;
    end else begin
      up = acc ? (s == 2'b01) : mDirUp;
      if (acc) mDirUp = (s == 2'b01);
      expOl = up && (mLevel == OL - 1);
      if (up && mLevel < OL) mLevel++;
      else if (!up && mLevel > 0) mLevel--;
      expSc = 1'b0;
      if (acc) begin
        if (s == 2'b10) begin
          if (mRun == RUN - 1) begin expSc = 1'b1; mRun = 0; end
          else mRun++;
        end else begin
          mRun = 0;
        end
      end
    end
  endfunction

  // called at a falling edge; applies inputs, models the rising edge, checks at the next falling edge
  task automatic step(input bit v, input bit [1:0] s, input bit d, input bit c, input string tag);
    termValid = v; termSource = s; drvActive = d; clrCounters = c;
    @(posedge clk);
    modelEdge(v, s, d, c);
    @(negedge clk);
    termValid = 1'b0; clrCounters = 1'b0;
    check(overloadFault, expOl, {tag, " overloadFault"});
    check(shortFault, expSc, {tag, " shortFault"});
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 2'b00, 1'b1, 1'b0, tag);
  endtask

  task automatic report(input bit [1:0] s, input string tag);
    step(1'b1, s, 1'b1, 1'b0, tag);
  endtask

  initial begin
    int unsigned seed;
    int unsigned r;
    seed = 32'd20240611;
    r = $urandom(seed);
    repeat (3) @(negedge clk);
    check(overloadFault, 1'b0, "R1 reset overloadFault");
    check(shortFault, 1'b0, "R1 reset shortFault");
    rstN = 1'b1;
    drvActive = 1'b1;
    @(negedge clk);
    idle(OL + 5, "R1 idle after reset");

    // R2/R5: sustained current limit reaches expiry once, then holds (R4)
    report(2'b01, "R2 current limit");
    idle(OL + 10, "R5 expiry and saturation");

    // R3: drain partly, climb back: integration without reset
    report(2'b00, "R3 pwm ends pulse");
    idle(19, "R3 draining");
    report(2'b01, "R3 climb again");
    idle(25, "R5 refire after drain");

    // R4: drain to zero and stay, then a full climb is needed
    report(2'b11, "R4 duty clamp");
    idle(OL + 20, "R4 floor");
    report(2'b01, "R4 climb from floor");
    idle(OL, "R4 full climb");
    report(2'b10, "R3 short counts down");
    idle(OL + 2, "R3 drain");

    // R6: consecutive short-circuit run
    for (int i = 0; i < RUN; i++) begin report(2'b10, "R6 short run"); idle(3, "R6 gap"); end
    for (int i = 0; i < RUN; i++) report(2'b10, "R6 back to back");

    // R7: broken run
    for (int i = 0; i < RUN - 1; i++) report(2'b10, "R7 partial run");
    report(2'b00, "R7 break");
    for (int i = 0; i < RUN - 1; i++) report(2'b10, "R7 no fault yet");
    report(2'b10, "R7 completes");

    // R8: reports with drive low are ignored
    for (int i = 0; i < RUN - 1; i++) report(2'b10, "R8 partial run");
    step(1'b1, 2'b00, 1'b0, 1'b0, "R8 ignored break");
    step(1'b1, 2'b01, 1'b0, 1'b0, "R8 ignored curlim");
    idle(2, "R8 no climb");
    report(2'b10, "R8 run still intact");

    // R9: clear before expiry and during a run
    report(2'b01, "R9 climb");
    idle(OL - 3, "R9 climb");
    step(1'b0, 2'b00, 1'b1, 1'b1, "R9 clear");
    idle(OL + 2, "R9 no fault after clear");
    for (int i = 0; i < RUN - 1; i++) report(2'b10, "R9 partial run");
    step(1'b1, 2'b10, 1'b1, 1'b1, "R9 clear overrides report");
    report(2'b10, "R9 run restarted");
    report(2'b01, "R9 up");
    idle(OL - 2, "R9 up");
    step(1'b1, 2'b01, 1'b1, 1'b1, "R9 clear at expiry edge");
    idle(3, "R9 after clear");

    // random mix
    for (int i = 0; i < 6000; i++) begin
      bit v; bit [1:0] s; bit d; bit c;
      r = $urandom();
      v = (r[3:0] < 4'd5);
      s = r[5:4];
      if (r[9:8] == 2'b11 && r[7]) s = 2'b01;
      d = (r[12:10] != 3'd0);
      c = (r[23:16] == 8'd7);
      step(v, s, d, c, "random R2 R3 R6 R7 R8");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule